// File: doc/BRIEF.md
# Single-Channel Block Transfer Engine

This block copies a run of words between a peripheral data port and memory so the processor does not have to move each word itself. Software programs a start memory address, a word count, a peripheral port number and the transfer options through a four-entry register interface, then sets a launch bit. The engine asks for the memory bus with a request/grant handshake and issues one memory access per word at sequential addresses. When the last word has moved, it raises an interrupt that stays up until software acknowledges it.

Two bus-holding policies are offered. In cycle-stealing mode the engine takes the bus for a single memory access and drops its request before it touches the next word. In burst mode it keeps its request up from launch to completion. The peripheral side is a pair of valid/ready streams, one per direction, and the engine waits for as long as the device is not ready.

The controller has seven states. IDLE leaves on a launch with a nonzero count: to FETCH when moving device to memory, or to ACQUIRE when moving memory to device. FETCH waits for a device word and then goes to ACQUIRE. ACQUIRE waits for the grant and then goes to WRITE (device to memory) or to READ (memory to device). WRITE returns to IDLE after the last word and otherwise to FETCH. READ always goes to LATCH, and LATCH always goes to SEND. SEND waits for the device to accept the word, then returns to IDLE after the last word or to ACQUIRE otherwise.

Top module: `dma_engine`

## Requirements
- R1: Register index 0 holds the memory address, index 1 the word count, index 2 the peripheral port number (driven on `dev_port`), and index 3 is control/status. All four can be written while idle and read back. A control write uses bit 0 as launch, bit 1 as direction (1 = memory to device, 0 = device to memory), bit 2 as burst mode and bit 3 as done-acknowledge. A status read returns busy in bit 0, direction in bit 1, burst in bit 2 and done in bit 3.
- R2: `mem_en` is asserted only in a cycle where both `bus_req` and `bus_gnt` are high.
- R3: After each word, the address register increases by one and the count register decreases by one. On completion the address reads start + count and the count reads 0.
- R4: In device-to-memory transfers, the k-th word accepted on the receive stream is written to memory address start + k.
- R5: In memory-to-device transfers, the word at address start + k is the k-th word presented on the transmit stream. While `dev_tx_ready` is low, `dev_tx_valid` and `dev_tx_data` hold steady.
- R6: In cycle-stealing mode, exactly one memory access happens per grant. `bus_req` is low in the cycle after each write and for the whole time a word waits at the device, so an n-word block sees n separate grants.
- R7: In burst mode, `bus_req` stays high from launch to completion, so a block sees exactly one grant.
- R8: Status bit 0 (busy) reads 1 from the cycle after a launch with a nonzero count until the transfer completes, and 0 afterwards.
- R9: `irq` and status bit 3 rise at completion and stay high until a control write with bit 3 set.
- R10: A launch with a count of 0 completes on the same clock edge: `irq` is high in the next cycle, busy never reads 1, and `bus_req` is never asserted.
- R11: While busy, writes to the address, count, port or options have no effect, and a second launch is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register index |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data for `reg_sel`, combinational |
| bus_req | output | 1 | Bus mastership request |
| bus_gnt | input | 1 | Bus mastership grant |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid the cycle after a read strobe |
| dev_port | output | PW | Programmed peripheral port number |
| dev_rx_valid | input | 1 | Device offers a word |
| dev_rx_ready | output | 1 | Engine accepts a device word |
| dev_rx_data | input | DW | Device word |
| dev_tx_valid | output | 1 | Engine offers a word to the device |
| dev_tx_ready | input | 1 | Device accepts the word |
| dev_tx_data | output | DW | Word sent to the device |
| irq | output | 1 | Completion interrupt |

## Verification
The hardest case to reach from the ports is a word stalled on both sides at once. A burst transfer can hold the bus while the device withholds data, and a cycle-stealing transfer can stall at the device after it has already dropped its request. The bench gets there with a grant that comes after a random delay and device valid/ready signals that toggle at random. It repeats this over random start addresses, counts, directions and modes, and counts grant rising edges to tell the two bus policies apart. It also rewrites the registers in the middle of long blocks, and it launches a zero-length block to check completion without any bus request.

// File: rtl/dma_pkg.sv
package dma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_ACQUIRE,
        ST_WRITE,
        ST_READ,
        ST_LATCH,
        ST_SEND
    } xfer_state_e;

    localparam int SEL_W = 2;
    localparam logic [SEL_W-1:0] SEL_ADDR  = 2'd0;
    localparam logic [SEL_W-1:0] SEL_COUNT = 2'd1;
    localparam logic [SEL_W-1:0] SEL_PORT  = 2'd2;
    localparam logic [SEL_W-1:0] SEL_CTRL  = 2'd3;

    localparam int BIT_GO    = 0;
    localparam int BIT_TODEV = 1;
    localparam int BIT_BURST = 2;
    localparam int BIT_ACK   = 3;

endpackage

// File: rtl/dma_regfile.sv
module dma_regfile
    import dma_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int PW = 8,
    parameter int DW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [SEL_W-1:0] reg_sel,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    input  logic             busy,
    input  logic             step,
    input  logic             finish,
    output logic [AW-1:0]    cur_addr,
    output logic [CW-1:0]    cur_cnt,
    output logic [PW-1:0]    port,
    output logic             cfg_dir,
    output logic             cfg_burst,
    output logic             start_go,
    output logic             start_dir,
    output logic             done
);

    logic ctrl_wr;
    logic cfg_wr;

    assign ctrl_wr   = reg_wr && (reg_sel == SEL_CTRL);
    assign cfg_wr    = reg_wr && !busy;
    assign start_go  = ctrl_wr && !busy && reg_wdata[BIT_GO];
    assign start_dir = reg_wdata[BIT_TODEV];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr  <= '0;
            cur_cnt   <= '0;
            port      <= '0;
            cfg_dir   <= 1'b0;
            cfg_burst <= 1'b0;
            done      <= 1'b0;
        end else begin
            if (step) begin
                cur_addr <= cur_addr + AW'(1);
                cur_cnt  <= cur_cnt - CW'(1);
            end else if (cfg_wr) begin
                unique case (reg_sel)
                    SEL_ADDR:  cur_addr <= reg_wdata[AW-1:0];
                    SEL_COUNT: cur_cnt  <= reg_wdata[CW-1:0];
                    SEL_PORT:  port     <= reg_wdata[PW-1:0];
                    SEL_CTRL: begin
                        cfg_dir   <= reg_wdata[BIT_TODEV];
                        cfg_burst <= reg_wdata[BIT_BURST];
                    end
                    default: ;
                endcase
            end
            if (finish) begin
                done <= 1'b1;
            end else if (ctrl_wr && reg_wdata[BIT_ACK]) begin
                done <= 1'b0;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_sel)
            SEL_ADDR:  reg_rdata[AW-1:0] = cur_addr;
            SEL_COUNT: reg_rdata[CW-1:0] = cur_cnt;
            SEL_PORT:  reg_rdata[PW-1:0] = port;
            SEL_CTRL: begin
                reg_rdata[BIT_GO]    = busy;
                reg_rdata[BIT_TODEV] = cfg_dir;
                reg_rdata[BIT_BURST] = cfg_burst;
                reg_rdata[BIT_ACK]   = done;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/dma_fsm.sv
module dma_fsm
    import dma_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_go,
    input  logic          start_dir,
    input  logic          cfg_dir,
    input  logic          cfg_burst,
    input  logic [CW-1:0] cur_cnt,
    input  logic          bus_gnt,
    input  logic          dev_rx_valid,
    input  logic          dev_tx_ready,
    output logic          busy,
    output logic          bus_req,
    output logic          mem_en,
    output logic          mem_we,
    output logic          dev_rx_ready,
    output logic          dev_tx_valid,
    output logic          load_dev,
    output logic          load_mem,
    output logic          step,
    output logic          finish
);

    xfer_state_e state, state_nx;
    logic        cnt_zero;
    logic        cnt_last;

    assign cnt_zero = (cur_cnt == '0);
    assign cnt_last = (cur_cnt == CW'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start_go && !cnt_zero) begin
                    state_nx = start_dir ? ST_ACQUIRE : ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (dev_rx_valid) state_nx = ST_ACQUIRE;
            end
            ST_ACQUIRE: begin
                if (bus_gnt) state_nx = cfg_dir ? ST_READ : ST_WRITE;
            end
            ST_WRITE: state_nx = cnt_last ? ST_IDLE : ST_FETCH;
            ST_READ:  state_nx = ST_LATCH;
            ST_LATCH: state_nx = ST_SEND;
            ST_SEND: begin
                if (dev_tx_ready) state_nx = cnt_zero ? ST_IDLE : ST_ACQUIRE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        busy         = (state != ST_IDLE);
        bus_req      = 1'b0;
        mem_en       = 1'b0;
        mem_we       = 1'b0;
        dev_rx_ready = 1'b0;
        dev_tx_valid = 1'b0;
        load_dev     = 1'b0;
        load_mem     = 1'b0;
        step         = 1'b0;
        finish       = 1'b0;
        unique case (state)
            ST_IDLE: begin
                finish = start_go && cnt_zero;
            end
            ST_FETCH: begin
                bus_req      = cfg_burst;
                dev_rx_ready = 1'b1;
                load_dev     = dev_rx_valid;
            end
            ST_ACQUIRE: begin
                bus_req = 1'b1;
            end
            ST_WRITE: begin
                bus_req = 1'b1;
                mem_en  = 1'b1;
                mem_we  = 1'b1;
                step    = 1'b1;
                finish  = cnt_last;
            end
            ST_READ: begin
                bus_req = 1'b1;
                mem_en  = 1'b1;
                step    = 1'b1;
            end
            ST_LATCH: begin
                bus_req  = 1'b1;
                load_mem = 1'b1;
            end
            ST_SEND: begin
                bus_req      = cfg_burst;
                dev_tx_valid = 1'b1;
                finish       = dev_tx_ready && cnt_zero;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/dma_holdreg.sv
module dma_holdreg #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_dev,
    input  logic [DW-1:0] dev_data,
    input  logic          load_mem,
    input  logic [DW-1:0] mem_data,
    output logic [DW-1:0] q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load_dev) begin
            q <= dev_data;
        end else if (load_mem) begin
            q <= mem_data;
        end
    end

endmodule

// File: rtl/dma_engine.sv
module dma_engine
    import dma_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int PW = 8,
    parameter int DW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [SEL_W-1:0] reg_sel,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    output logic             bus_req,
    input  logic             bus_gnt,
    output logic             mem_en,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    input  logic [DW-1:0]    mem_rdata,
    output logic [PW-1:0]    dev_port,
    input  logic             dev_rx_valid,
    output logic             dev_rx_ready,
    input  logic [DW-1:0]    dev_rx_data,
    output logic             dev_tx_valid,
    input  logic             dev_tx_ready,
    output logic [DW-1:0]    dev_tx_data,
    output logic             irq
);

    logic [AW-1:0] cur_addr;
    logic [CW-1:0] cur_cnt;
    logic          cfg_dir;
    logic          cfg_burst;
    logic          start_go;
    logic          start_dir;
    logic          busy;
    logic          step;
    logic          finish;
    logic          load_dev;
    logic          load_mem;
    logic [DW-1:0] hold_q;

    dma_regfile #(.AW(AW), .CW(CW), .PW(PW), .DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (busy),
        .step      (step),
        .finish    (finish),
        .cur_addr  (cur_addr),
        .cur_cnt   (cur_cnt),
        .port      (dev_port),
        .cfg_dir   (cfg_dir),
        .cfg_burst (cfg_burst),
        .start_go  (start_go),
        .start_dir (start_dir),
        .done      (irq)
    );

    dma_fsm #(.CW(CW)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_go     (start_go),
        .start_dir    (start_dir),
        .cfg_dir      (cfg_dir),
        .cfg_burst    (cfg_burst),
        .cur_cnt      (cur_cnt),
        .bus_gnt      (bus_gnt),
        .dev_rx_valid (dev_rx_valid),
        .dev_tx_ready (dev_tx_ready),
        .busy         (busy),
        .bus_req      (bus_req),
        .mem_en       (mem_en),
        .mem_we       (mem_we),
        .dev_rx_ready (dev_rx_ready),
        .dev_tx_valid (dev_tx_valid),
        .load_dev     (load_dev),
        .load_mem     (load_mem),
        .step         (step),
        .finish       (finish)
    );

    dma_holdreg #(.DW(DW)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_dev (load_dev),
        .dev_data (dev_rx_data),
        .load_mem (load_mem),
        .mem_data (mem_rdata),
        .q        (hold_q)
    );

    assign mem_addr    = cur_addr;
    assign mem_wdata   = hold_q;
    assign dev_tx_data = hold_q;

    logic unused_wdata_bits;
    assign unused_wdata_bits = ^reg_wdata;

endmodule

// File: rtl/dma_engine_chk.sv
module dma_engine_chk #(
    parameter int DW = 32,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr,
    input logic [1:0]    reg_sel,
    input logic [DW-1:0] reg_wdata,
    input logic          bus_req,
    input logic          bus_gnt,
    input logic          mem_en,
    input logic          mem_we,
    input logic          dev_tx_valid,
    input logic          dev_tx_ready,
    input logic [DW-1:0] dev_tx_data,
    input logic          irq,
    input logic          cfg_burst,
    input logic          busy,
    input logic [CW-1:0] cur_cnt
);

    a_r2_access_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> (bus_req && bus_gnt));

    a_r6_release_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we && !cfg_burst) |=> !bus_req);

    a_r6_no_hold_while_sending: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_tx_valid && !cfg_burst) |-> !bus_req);

    a_r7_burst_keeps_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && cfg_burst) |=> (bus_req || !busy));

    a_r5_tx_held: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_tx_valid && !dev_tx_ready) |=> (dev_tx_valid && $stable(dev_tx_data)));

    a_r9_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(reg_wr && reg_sel == 2'd3 && reg_wdata[3])) |=> irq);

    a_r10_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == 2'd3 && reg_wdata[0] && !busy && cur_cnt == '0)
        |=> (irq && !bus_req && !busy));

endmodule

bind dma_engine dma_engine_chk #(.DW(DW), .CW(CW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_sel      (reg_sel),
    .reg_wdata    (reg_wdata),
    .bus_req      (bus_req),
    .bus_gnt      (bus_gnt),
    .mem_en       (mem_en),
    .mem_we       (mem_we),
    .dev_tx_valid (dev_tx_valid),
    .dev_tx_ready (dev_tx_ready),
    .dev_tx_data  (dev_tx_data),
    .irq          (irq),
    .cfg_burst    (cfg_burst),
    .busy         (busy),
    .cur_cnt      (cur_cnt)
);

// File: tb/dma_engine_test.sv
module dma_engine_test;
    localparam int AW = 16;
    localparam int CW = 16;
    localparam int PW = 8;
    localparam int DW = 32;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_sel = 2'd3;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          bus_req, bus_gnt = 1'b0;
    logic          mem_en, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata = '0;
    logic [PW-1:0] dev_port;
    logic          dev_rx_valid = 1'b0, dev_rx_ready;
    logic [DW-1:0] dev_rx_data;
    logic          dev_tx_valid, dev_tx_ready = 1'b0;
    logic [DW-1:0] dev_tx_data;
    logic          irq;

    dma_engine #(.AW(AW), .CW(CW), .PW(PW), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_req(bus_req),
        .bus_gnt(bus_gnt), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .dev_port(dev_port),
        .dev_rx_valid(dev_rx_valid), .dev_rx_ready(dev_rx_ready),
        .dev_rx_data(dev_rx_data), .dev_tx_valid(dev_tx_valid),
        .dev_tx_ready(dev_tx_ready), .dev_tx_data(dev_tx_data), .irq(irq)
    );

    int          vectors = 0;
    int          miscompares = 0;
    int unsigned cycles = 0;
    logic        clr = 1'b0;
    int unsigned gnt_rises = 0;
    int unsigned src_idx = 0;
    int unsigned snk_idx = 0;
    logic        req_seen = 1'b0;
    logic        gnt_q = 1'b0;
    logic [DW-1:0] bmem [64];
    logic [DW-1:0] snk_log [64];
    logic [DW-1:0] salt = '0;
    logic [AW-1:0] base = '0;

    function automatic logic [DW-1:0] pat(int unsigned k, logic [DW-1:0] s);
        return s ^ (32'h0001_0003 * (k + 1)) ^ (k << 24);
    endfunction

    // memory model: synchronous read, data valid the cycle after the strobe
    always @(posedge clk) begin
        if (mem_en && !mem_we) mem_rdata <= pat(int'(AW'(mem_addr - base)), salt);
        if (mem_en && mem_we) bmem[mem_addr[5:0]] <= mem_wdata;
    end

    // bus arbiter: random grant delay, grant held while requested
    always @(posedge clk) begin
        if (!rst_n || !bus_req) bus_gnt <= 1'b0;
        else if (!bus_gnt) bus_gnt <= (($urandom % 3) == 0);
        gnt_q <= bus_gnt;
        if (clr) begin
            gnt_rises <= 0;
            req_seen  <= 1'b0;
            src_idx   <= 0;
            snk_idx   <= 0;
        end else begin
            if (bus_gnt && !gnt_q) gnt_rises <= gnt_rises + 1;
            if (bus_req) req_seen <= 1'b1;
            if (dev_rx_valid && dev_rx_ready) src_idx <= src_idx + 1;
            if (dev_tx_valid && dev_tx_ready) begin
                snk_log[snk_idx[5:0]] <= dev_tx_data;
                snk_idx <= snk_idx + 1;
            end
        end
    end

    assign dev_rx_data = pat(src_idx, salt);

    always @(negedge clk) begin
        dev_rx_valid <= (($urandom % 4) != 0);
        dev_tx_ready <= (($urandom % 4) != 0);
    end

    task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            miscompares++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            finish_run();
        end
    end

    task automatic reg_write(logic [1:0] sel, logic [DW-1:0] data);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0; reg_sel = 2'd3; reg_wdata = '0;
    endtask

    task automatic reg_read(logic [1:0] sel, output logic [DW-1:0] data);
        @(negedge clk);
        reg_sel = sel;
        #1 data = reg_rdata;
        reg_sel = 2'd3;
    endtask

    task automatic run_xfer(int unsigned start, int unsigned n, bit to_dev, bit burst, bit disturb);
        logic [DW-1:0] rd;
        int waited;
        salt = $urandom;
        base = AW'(start);
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        reg_write(2'd0, DW'(start));
        reg_write(2'd1, DW'(n));
        reg_write(2'd2, DW'(8'h40 + n));
        reg_write(2'd3, {28'd0, 1'b0, burst, to_dev, 1'b1});
        #1 check("R8 busy after launch", DW'(reg_rdata[0]), 1);
        if (disturb) begin
            reg_write(2'd0, 32'h0000_003F);
            reg_write(2'd1, 32'd7);
            reg_write(2'd3, {28'd0, 1'b0, ~burst, ~to_dev, 1'b1});
        end
        waited = 0;
        while (!irq && waited < 5000) begin
            @(negedge clk);
            waited++;
        end
        check("R9 irq at completion", DW'(irq), 1);
        reg_read(2'd3, rd);
        check("R8 busy cleared", DW'(rd[0]), 0);
        check("R9 done status", DW'(rd[3]), 1);
        check("R1 options read back", DW'(rd[2:1]), DW'({burst, to_dev}));
        reg_read(2'd0, rd);
        check(disturb ? "R11 R3 address after busy write" : "R3 final address", rd, DW'(AW'(start + n)));
        reg_read(2'd1, rd);
        check("R3 final count", rd, 0);
        check("R1 port pin", DW'(dev_port), DW'(8'h40 + n));
        if (burst) check("R7 one grant per block", gnt_rises, 1);
        else       check("R6 one grant per word", gnt_rises, n);
        for (int k = 0; k < int'(n); k++) begin
            if (to_dev) check("R5 word sent to device", snk_log[k], pat(k, salt));
            else        check("R4 word written to memory", bmem[(start + k) % 64], pat(k, salt));
        end
        if (to_dev) check("R5 word count at device", snk_idx, n);
        repeat (3) @(negedge clk);
        check("R9 irq held", DW'(irq), 1);
        reg_write(2'd3, 32'h8);
        check("R9 irq acknowledged", DW'(irq), 0);
    endtask

    initial begin
        logic [DW-1:0] rd;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("reset irq", DW'(irq), 0);
        check("reset bus_req", DW'(bus_req), 0);
        check("reset mem_en", DW'(mem_en), 0);
        reg_read(2'd3, rd);
        check("reset status", rd, 0);

        // R1: idle register readback
        reg_write(2'd0, 32'h0000_1234);
        reg_write(2'd1, 32'h0000_0042);
        reg_write(2'd2, 32'h0000_00A7);
        reg_read(2'd0, rd); check("R1 address readback", rd, 32'h1234);
        reg_read(2'd1, rd); check("R1 count readback", rd, 32'h42);
        reg_read(2'd2, rd); check("R1 port readback", rd, 32'hA7);
        check("R1 port pin", DW'(dev_port), 32'hA7);

        // R10: zero-length launch
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        reg_write(2'd1, 32'd0);
        reg_write(2'd3, 32'h5);
        check("R10 irq right after zero launch", DW'(irq), 1);
        reg_read(2'd3, rd);
        check("R10 never busy", DW'(rd[0]), 0);
        check("R10 no bus request", DW'(req_seen), 0);
        reg_write(2'd3, 32'h8);
        check("R9 irq acknowledged", DW'(irq), 0);

        // directed: all direction/mode combinations
        run_xfer(4, 5, 1'b0, 1'b0, 1'b0);
        run_xfer(10, 5, 1'b0, 1'b1, 1'b1);
        run_xfer(20, 6, 1'b1, 1'b0, 1'b1);
        run_xfer(30, 6, 1'b1, 1'b1, 1'b0);
        run_xfer(50, 1, 1'b1, 1'b0, 1'b0);
        run_xfer(51, 1, 1'b0, 1'b1, 1'b0);

        // random mix
        for (int t = 0; t < 14; t++) begin
            int unsigned n;
            int unsigned st;
            n  = 1 + ($urandom % 12);
            st = $urandom % 41;
            run_xfer(st, n, 1'($urandom % 2), 1'($urandom % 2), (n >= 4) && ($urandom % 2 == 1));
        end

        finish_run();
    end

endmodule